// File: doc/BRIEF.md
# Register-Sourced Two-Input Bitwise Lookup Unit

This execution unit applies a two-input boolean function to every bit of a pair of 64-bit operands. The function is not fixed in the instruction. It is a four-entry truth table taken at run time from the low byte of a third operand. One bit of the instruction picks either the lowest nibble or the nibble just above it as the table. Two such operations, one for each nibble, can then be merged to build a dynamic three-input function.

The unit decodes a 32-bit instruction word. Bits are numbered big-endian, so bit 0 is the word's MSB. It checks the primary opcode (bits 0-5) and the extended opcode (bits 27-31) against parameter values. It takes the destination index from bits 6-10 and the half-select flag from bit 26. Operand values arrive on separate ports together with `in_valid`. The result is registered and presented with `out_valid` one clock later. The unit writes no flag or condition register.

When the word carries foreign opcodes, the result is suppressed and a "not mine" flag is raised instead.

Top module: `dlut_unit`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle in which `in_valid` was high, and low in the cycle after a cycle in which `in_valid` was low.
- R2: A synchronous `rst` clears `out_valid` and `out_not_mine`, and clears `out_rt` to zero.
- R3: The instruction word is read big-endian, as follows:
  - primary opcode: word bits 31..26 (bits 0-5)
  - destination index: bits 25..21 (bits 6-10), presented on `out_rt_idx` together with the result
  - half-select flag: bit 5 (bit 26)
  - extended opcode: bits 4..0 (bits 27-31)
- R4: When the half-select flag is 0, the table is `in_rc[3:0]`. When it is 1, the table is `in_rc[7:4]`.
- R5: For every bit k, the value j = {in_ra[k], in_rb[k]} (in_ra as the MSB) selects table entry j. Entry 0 is the most significant bit of the chosen nibble and entry 3 is its least significant bit, so `out_rt[k]` = nibble[3-j].
- R6: Bits of `in_rc` outside the selected nibble have no effect on `out_rt`.
- R7: If the primary opcode differs from `PRI_OP` or the extended opcode differs from `EXT_OP`, `out_not_mine` is high together with `out_valid` and `out_rt` is all zeros. `out_not_mine` is never high without `out_valid`.
- R8: For a matching instruction, `out_not_mine` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and instruction are present this cycle |
| in_instr | input | 32 | Instruction word |
| in_ra | input | XLEN | First lookup operand |
| in_rb | input | XLEN | Second lookup operand |
| in_rc | input | XLEN | Operand holding the truth-table byte |
| out_valid | output | 1 | Result present |
| out_not_mine | output | 1 | Instruction was not for this unit; result suppressed |
| out_rt | output | XLEN | Lookup result |
| out_rt_idx | output | 5 | Destination register index |

## Verification
The assertions assume the following about the inputs:
- `in_valid` and `rst` are never unknown after the first clock edge.
- Instruction and operand values are stable while `in_valid` is sampled.

The bench meets these assumptions by driving every input only on the falling edge. All inputs are defined from time zero, and the operands are randomized only together with a defined `in_valid`. Random instruction words mostly carry the matching opcodes. A share of them gets a corrupted primary or extended opcode to exercise suppression. Directed cases cover:
- all-zero and all-ones operands
- every table value under both halves
- noise in the unused bytes of `in_rc`

// File: rtl/dlut_pkg.sv
package dlut_pkg;

   localparam int INSTR_W = 32;
   localparam int NIB_W   = 4;

   // Word fields in MSB-first order: word bit 31 is big-endian bit 0.
   typedef struct packed {
      logic [5:0] pri_op;
      logic [4:0] dst;
      logic [4:0] src_a;
      logic [4:0] src_b;
      logic [4:0] src_tab;
      logic       hi_half;
      logic [4:0] ext_op;
   } dlut_word_t;

endpackage

// File: rtl/dlut_decode.sv
module dlut_decode
   import dlut_pkg::*;
#(
   parameter logic [5:0] PRI_OP = 6'd22,
   parameter logic [4:0] EXT_OP = 5'd9
) (
   input  logic [INSTR_W-1:0] instr,
   output logic [4:0]         dst,
   output logic               hi_half,
   output logic               match
);
   dlut_word_t w;

   always_comb begin
      w       = dlut_word_t'(instr);
      dst     = w.dst;
      hi_half = w.hi_half;
      match   = (w.pri_op == PRI_OP) && (w.ext_op == EXT_OP);
   end
endmodule

// File: rtl/dlut_table_sel.sv
module dlut_table_sel
   import dlut_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0]  rc,
   input  logic             hi_half,
   output logic [NIB_W-1:0] nib
);
   initial begin
      if (XLEN < 2*NIB_W) $error("dlut_table_sel: XLEN too small for two nibbles");
   end

   always_comb begin
      nib = hi_half ? rc[2*NIB_W-1:NIB_W] : rc[NIB_W-1:0];
   end
endmodule

// File: rtl/dlut_bit_array.sv
module dlut_bit_array
   import dlut_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0]  a,
   input  logic [XLEN-1:0]  b,
   input  logic [NIB_W-1:0] nib,
   output logic [XLEN-1:0]  y
);
   // Entry j = {a,b} sits at nibble bit (3 - j).
   for (genvar k = 0; k < XLEN; k++) begin : g_bit
      always_comb begin
         unique case ({a[k], b[k]})
            2'b00:   y[k] = nib[3];
            2'b01:   y[k] = nib[2];
            2'b10:   y[k] = nib[1];
            default: y[k] = nib[0];
         endcase
      end
   end
endmodule

// File: rtl/dlut_unit.sv
module dlut_unit
   import dlut_pkg::*;
#(
   parameter int         XLEN   = 64,
   parameter logic [5:0] PRI_OP = 6'd22,
   parameter logic [4:0] EXT_OP = 5'd9
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_valid,
   input  logic [INSTR_W-1:0]   in_instr,
   input  logic [XLEN-1:0]      in_ra,
   input  logic [XLEN-1:0]      in_rb,
   input  logic [XLEN-1:0]      in_rc,
   output logic                 out_valid,
   output logic                 out_not_mine,
   output logic [XLEN-1:0]      out_rt,
   output logic [4:0]           out_rt_idx
);
   initial begin
      if (XLEN < 8) $error("dlut_unit: XLEN must be at least 8");
   end

   logic [4:0]       dst;
   logic             hi_half;
   logic             match;
   logic [NIB_W-1:0] nib;
   logic [XLEN-1:0]  lut_y;

   dlut_decode #(.PRI_OP(PRI_OP), .EXT_OP(EXT_OP)) dec_i (
      .instr(in_instr), .dst(dst), .hi_half(hi_half), .match(match)
   );

   dlut_table_sel #(.XLEN(XLEN)) sel_i (
      .rc(in_rc), .hi_half(hi_half), .nib(nib)
   );

   dlut_bit_array #(.XLEN(XLEN)) arr_i (
      .a(in_ra), .b(in_rb), .nib(nib), .y(lut_y)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid    <= 1'b0;
         out_not_mine <= 1'b0;
         out_rt       <= '0;
         out_rt_idx   <= '0;
      end else begin
         out_valid    <= in_valid;
         out_not_mine <= in_valid && !match;
         out_rt       <= (in_valid && match) ? lut_y : '0;
         out_rt_idx   <= dst;
      end
   end
endmodule

// File: rtl/dlut_unit_chk.sv
module dlut_unit_chk
   import dlut_pkg::*;
#(
   parameter int         XLEN   = 64,
   parameter logic [5:0] PRI_OP = 6'd22,
   parameter logic [4:0] EXT_OP = 5'd9
) (
   input logic                clk,
   input logic                rst,
   input logic                in_valid,
   input logic [INSTR_W-1:0]  in_instr,
   input logic [XLEN-1:0]     in_ra,
   input logic [XLEN-1:0]     in_rb,
   input logic [XLEN-1:0]     in_rc,
   input logic                out_valid,
   input logic                out_not_mine,
   input logic [XLEN-1:0]     out_rt,
   input logic [4:0]          out_rt_idx
);
   logic ours;
   assign ours = (in_instr[31:26] == PRI_OP) && (in_instr[4:0] == EXT_OP);

   // R1
   valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   // R1
   no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   // R2
   reset_clears_chk: assert property (@(posedge clk)
      $past(rst) |-> (!out_valid && !out_not_mine));

   // R7
   foreign_zero_chk: assert property (@(posedge clk) disable iff (rst)
      out_not_mine |-> (out_valid && out_rt == '0));

   // R8
   ours_accepted_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && ours) |=> !out_not_mine);

   // R3
   dst_index_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_rt_idx == $past(in_instr[25:21]));

   // R5
   both_ones_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && ours && in_ra == '1 && in_rb == '1)
      |=> out_rt == {XLEN{$past(in_instr[5] ? in_rc[4] : in_rc[0])}});

   // R5
   both_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && ours && in_ra == '0 && in_rb == '0)
      |=> out_rt == {XLEN{$past(in_instr[5] ? in_rc[7] : in_rc[3])}});
endmodule

bind dlut_unit dlut_unit_chk #(.XLEN(XLEN), .PRI_OP(PRI_OP), .EXT_OP(EXT_OP)) chk_i (
   .clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr),
   .in_ra(in_ra), .in_rb(in_rb), .in_rc(in_rc),
   .out_valid(out_valid), .out_not_mine(out_not_mine),
   .out_rt(out_rt), .out_rt_idx(out_rt_idx)
);

// File: tb/dlut_unit_tb_top.sv
module dlut_unit_tb_top;
   localparam int         XLEN = 64;
   localparam logic [5:0] PO   = 6'd22;
   localparam logic [4:0] XO   = 5'd9;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            in_valid = 1'b0;
   logic [31:0]     in_instr = '0;
   logic [XLEN-1:0] in_ra = '0, in_rb = '0, in_rc = '0;
   logic            out_valid, out_not_mine;
   logic [XLEN-1:0] out_rt;
   logic [4:0]      out_rt_idx;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   dlut_unit #(.XLEN(XLEN), .PRI_OP(PO), .EXT_OP(XO)) dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr),
      .in_ra(in_ra), .in_rb(in_rb), .in_rc(in_rc),
      .out_valid(out_valid), .out_not_mine(out_not_mine),
      .out_rt(out_rt), .out_rt_idx(out_rt_idx)
   );

   // Sum-of-products model: table entry j is nibble bit (3-j).
   function automatic logic [XLEN-1:0] model(input logic [XLEN-1:0] a, b, rc, input logic hi);
      logic [3:0] t;
      t = hi ? rc[7:4] : rc[3:0];
      return (~a & ~b & {XLEN{t[3]}}) | (~a & b & {XLEN{t[2]}}) |
             ( a & ~b & {XLEN{t[1]}}) | ( a & b & {XLEN{t[0]}});
   endfunction

   function automatic logic [31:0] mkword(input logic [5:0] po, input logic [4:0] dst,
                                          input logic hi, input logic [4:0] xo);
      return {po, dst, 5'd1, 5'd2, 5'd3, hi, xo};
   endfunction

   task automatic chk(input string req, input logic [XLEN-1:0] act, exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Issue one operation on a falling edge and check it at the next falling edge.
   task automatic issue(input string req, input logic [31:0] w,
                        input logic [XLEN-1:0] a, b, rc);
      logic ours;
      logic [XLEN-1:0] exp;
      ours = (w[31:26] == PO) && (w[4:0] == XO);
      exp  = ours ? model(a, b, rc, w[5]) : '0;
      in_valid = 1'b1; in_instr = w; in_ra = a; in_rb = b; in_rc = rc;
      @(negedge clk);
      in_valid = 1'b0;
      chk({req, " R1 valid"}, XLEN'(out_valid), XLEN'(1));
      chk({req, " R7/R8 not_mine"}, XLEN'(out_not_mine), XLEN'(!ours));
      chk({req, " R5 rt"}, out_rt, exp);
      chk({req, " R3 idx"}, XLEN'(out_rt_idx), XLEN'(w[25:21]));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      logic [XLEN-1:0] a, b, rc, r1, r2;
      logic [31:0] w;
      void'($urandom(32'd20240611));

      // Reset state
      repeat (3) @(negedge clk);
      chk("R2 valid after reset", XLEN'(out_valid), '0);
      chk("R2 not_mine after reset", XLEN'(out_not_mine), '0);
      chk("R2 rt after reset", out_rt, '0);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 idle no valid", XLEN'(out_valid), '0);

      // Every table value under each half, R4 with all four input combinations present
      a = 64'hFFFF_0000_FFFF_0000;
      b = 64'hFF00_FF00_FF00_FF00;
      for (int t = 0; t < 16; t++) begin
         issue("R4 low half", mkword(PO, 5'(t), 1'b0, XO), a, b, {56'hA5A5_5A5A_C3C3_3C, 4'hF - 4'(t), 4'(t)});
         issue("R4 high half", mkword(PO, 5'(t+7), 1'b1, XO), a, b, {56'h0F0F_F0F0_9696_69, 4'(t), 4'hF - 4'(t)});
      end

      // Corner operands
      issue("R5 zeros", mkword(PO, 5'd31, 1'b0, XO), '0, '0, 64'h8);
      issue("R5 ones", mkword(PO, 5'd0, 1'b1, XO), '1, '1, 64'h10);
      issue("R5 a only", mkword(PO, 5'd4, 1'b0, XO), '1, '0, 64'h2);
      issue("R5 b only", mkword(PO, 5'd5, 1'b1, XO), '0, '1, 64'h40);

      // R6: changing bits outside selected nibble leaves result unchanged
      a = {$urandom, $urandom}; b = {$urandom, $urandom};
      w = mkword(PO, 5'd9, 1'b0, XO);
      issue("R6 base", w, a, b, 64'h0000_0000_0000_0006);
      r1 = out_rt;
      issue("R6 noisy", w, a, b, 64'hDEAD_BEEF_1234_56F6);
      r2 = out_rt;
      chk("R6 low half unaffected", r2, r1);
      w = mkword(PO, 5'd9, 1'b1, XO);
      issue("R6 base hi", w, a, b, 64'h0000_0000_0000_0090);
      r1 = out_rt;
      issue("R6 noisy hi", w, a, b, 64'hFFFF_FFFF_FFFF_FF9F);
      r2 = out_rt;
      chk("R6 high half unaffected", r2, r1);

      // R7: foreign opcodes
      issue("R7 bad primary", mkword(PO ^ 6'd1, 5'd3, 1'b0, XO), '1, '0, 64'hF);
      issue("R7 bad extended", mkword(PO, 5'd3, 1'b1, XO ^ 5'd16), '0, '0, 64'hFF);

      // R1: gap cycle produces no valid
      @(negedge clk);
      chk("R1 gap no valid", XLEN'(out_valid), '0);

      // Random mix
      for (int n = 0; n < 400; n++) begin
         w = {$urandom};
         if (($urandom % 10) < 8) begin
            w[31:26] = PO; w[4:0] = XO;
         end
         issue("rand", w, {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom});
         if (($urandom % 4) == 0) begin
            @(negedge clk);
            chk("R1 rand gap", XLEN'(out_valid), '0);
         end
      end

      // Reset mid-stream
      in_valid = 1'b1; in_instr = mkword(PO ^ 6'd3, 5'd1, 1'b0, XO);
      rst = 1'b1;
      @(negedge clk);
      in_valid = 1'b0; rst = 1'b0;
      chk("R2 reset wins valid", XLEN'(out_valid), '0);
      chk("R2 reset wins not_mine", XLEN'(out_not_mine), '0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule